// File: doc/BRIEF.md
# Conditional Compare-and-Add Memory Unit

This unit performs one locked read-modify-write on a single memory word. A start pulse brings an opcode nibble, an operand size, an address, a comparand and an addend. The unit reads the word and subtracts the comparand from it. It then tests a selectable condition against that difference. If the condition holds, the unit writes back the old word plus the addend. If it does not hold, no write is issued. When the operation completes without a fault, the unit reports the old word and a set of arithmetic flags that describe the subtraction.

The control is a five-state machine:
- `ST_IDLE` goes to `ST_READ` on start.
- `ST_READ` goes to `ST_EVAL` on a clean read response, or to `ST_DONE` on a faulted read response.
- `ST_EVAL` goes to `ST_WRITE` when the condition holds, or to `ST_DONE` when it does not.
- `ST_WRITE` goes to `ST_DONE` on its response, faulted or not.
- `ST_DONE` returns to `ST_IDLE`.

The memory lock is held in `ST_READ`, `ST_EVAL` and `ST_WRITE`. No other access can therefore come between the read and the write. Decoding, address generation and register writeback belong to the surrounding pipeline.

Top module: `cond_xadd_unit`

## Requirements
- R1: After reset, `done`, `fault`, `mem_req`, `mem_we` and `mem_lock` are 0, and `old_val` and `flags` are all zeros.
- R2: A start in idle issues a read request at `addr` with `mem_lock` high. A request holds its address, direction and data until `mem_rsp`. Every write request carries the lock, and the lock stays high from the read request until the write response.
- R3: When the condition is false, no write request is issued and memory is unchanged. The lock drops after the read, and `done` follows.
- R4: `op_code[3:1]` selects the base condition: 0 overflow, 1 below (unsigned), 2 equal, 3 below-or-equal (unsigned), 4 sign, 5 parity, 6 less (signed), 7 less-or-equal (signed). `op_code[0]`=1 inverts it.
- R5: `flags` = {OF,SF,ZF,AF,PF,CF} (bits 5..0) describes memory minus comparand, whether or not the condition held. CF is the borrow, AF is the borrow out of bit 3, and OF is the sign bit of (mem^cmp)&(mem^diff).
- R6: The parity condition is true when bits 7:0 of the difference hold an even number of ones. Higher bits play no part.
- R7: Less and less-or-equal compare signed values of the operand width. Below and below-or-equal compare unsigned values.
- R8: With `wide`=0 only bits 31:0 of memory and operands count, and the sign is taken from bit 31. The written word and `old_val` are zero-extended. With `wide`=1 all 64 bits count and the sign is bit 63.
- R9: On a fault-free finish, `done` pulses and `old_val` holds the old memory value. When the condition held, memory holds old+addend at the operand width.
- R10: A fault response on the read or on the write ends the operation with `done` and `fault` high. `old_val` and `flags` keep their earlier contents, and the lock is released.
- R11: `done` lasts one cycle, and `fault` is only high with `done`. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only in idle) |
| op_code | input | 4 | Condition select [3:1] and invert [0] |
| wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| addr | input | ADDR_W | Word address |
| cmp_val | input | DATA_W | Comparand |
| add_val | input | DATA_W | Addend |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | 1 = write request |
| mem_lock | output | 1 | Locks memory across the read and the write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rsp | input | 1 | Response strobe |
| mem_rdata | input | DATA_W | Read data |
| mem_fault | input | 1 | Response carries a fault |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation ended in a fault (with done) |
| old_val | output | DATA_W | Old memory value of the last clean operation |
| flags | output | 6 | {OF,SF,ZF,AF,PF,CF} of the last clean operation |

## Verification
The bench builds the unit with its defaults: DATA_W=64 and ADDR_W=16. Operand size is a run-time input, so this one build covers both the 32-bit and the 64-bit paths. Identical bit patterns are run at both widths, and they give different signed, unsigned and overflow outcomes. A bench-side memory responder can inject faults on the read or on the write. It also counts reads, writes and unlocked writes. These counts show that a false condition issues no write and that a start while busy starts nothing.

// File: rtl/cxa_pkg.sv
package cxa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } cxa_state_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } cxa_flags_t;

    localparam int FLAG_W = $bits(cxa_flags_t);

endpackage

// File: rtl/cxa_flag_calc.sv
module cxa_flag_calc
    import cxa_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic              wide,
    output cxa_flags_t        flg
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0]   sub_ext;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] ovf_vec;
    logic [DATA_W-1:0] carry_vec;

    // Inputs arrive zero-extended in narrow mode, so the borrow sits at bit DATA_W either way.
    always_comb begin
        sub_ext   = {1'b0, mem_val} - {1'b0, cmp_val};
        diff      = sub_ext[DATA_W-1:0];
        ovf_vec   = (mem_val ^ cmp_val) & (mem_val ^ diff);
        carry_vec = mem_val ^ cmp_val ^ diff;

        flg.cf = sub_ext[DATA_W];
        flg.af = carry_vec[4];
        flg.pf = ~^diff[7:0];
        flg.zf = wide ? (diff == '0) : (diff[HALF_W-1:0] == '0);
        flg.sf = wide ? diff[DATA_W-1] : diff[HALF_W-1];
        flg.of = wide ? ovf_vec[DATA_W-1] : ovf_vec[HALF_W-1];
    end

endmodule

// File: rtl/cxa_cond_select.sv
module cxa_cond_select
    import cxa_pkg::*;
(
    input  cxa_flags_t flg,
    input  logic [3:0] code,
    output logic       take
);
    logic base;

    always_comb begin
        unique case (code[3:1])
            3'd0: base = flg.of;
            3'd1: base = flg.cf;
            3'd2: base = flg.zf;
            3'd3: base = flg.cf | flg.zf;
            3'd4: base = flg.sf;
            3'd5: base = flg.pf;
            3'd6: base = flg.sf ^ flg.of;
            3'd7: base = (flg.sf ^ flg.of) | flg.zf;
        endcase
        take = base ^ code[0];
    end

endmodule

// File: rtl/cond_xadd_unit.sv
module cond_xadd_unit
    import cxa_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op_code,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic [DATA_W-1:0] add_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_fault,
    output logic              done,
    output logic              fault,
    output logic [DATA_W-1:0] old_val,
    output logic [5:0]        flags
);
    localparam int HALF_W = DATA_W / 2;

    cxa_state_e        st, st_nx;
    logic [3:0]        op_r;
    logic              wide_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] cmp_r, add_r, mem_r, sum_w;
    logic [DATA_W-1:0] old_r;
    cxa_flags_t        flg_w, flg_r;
    logic              flt_r, take_w, commit_w, fail_w;

    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic w);
        return w ? v : {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    cxa_flag_calc #(.DATA_W(DATA_W)) u_flags (
        .mem_val (mem_r),
        .cmp_val (fit(cmp_r, wide_r)),
        .wide    (wide_r),
        .flg     (flg_w)
    );

    cxa_cond_select u_cond (
        .flg  (flg_w),
        .code (op_r),
        .take (take_w)
    );

    assign sum_w    = fit(mem_r + add_r, wide_r);
    assign fail_w   = ((st == ST_READ) || (st == ST_WRITE)) && mem_rsp && mem_fault;
    assign commit_w = ((st == ST_EVAL) && !take_w) ||
                      ((st == ST_WRITE) && mem_rsp && !mem_fault);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_READ;
            ST_READ:  if (mem_rsp) st_nx = mem_fault ? ST_DONE : ST_EVAL;
            ST_EVAL:  st_nx = take_w ? ST_WRITE : ST_DONE;
            ST_WRITE: if (mem_rsp) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Operand capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r   <= '0;
            wide_r <= 1'b0;
            addr_r <= '0;
            cmp_r  <= '0;
            add_r  <= '0;
            mem_r  <= '0;
            old_r  <= '0;
            flg_r  <= '0;
            flt_r  <= 1'b0;
        end else begin
            if ((st == ST_IDLE) && start) begin
                op_r   <= op_code;
                wide_r <= wide;
                addr_r <= addr;
                cmp_r  <= cmp_val;
                add_r  <= add_val;
                flt_r  <= 1'b0;
            end
            if ((st == ST_READ) && mem_rsp && !mem_fault)
                mem_r <= fit(mem_rdata, wide_r);
            if (fail_w)
                flt_r <= 1'b1;
            if (commit_w) begin
                old_r <= mem_r;
                flg_r <= flg_w;
            end
        end
    end

    assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
    assign mem_we    = (st == ST_WRITE);
    assign mem_lock  = (st == ST_READ) || (st == ST_EVAL) || (st == ST_WRITE);
    assign mem_addr  = addr_r;
    assign mem_wdata = sum_w;
    assign done      = (st == ST_DONE);
    assign fault     = (st == ST_DONE) && flt_r;
    assign old_val   = old_r;
    assign flags     = flg_r;

endmodule

// File: rtl/cxa_checker.sv
module cxa_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic              mem_rsp,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done,
    input logic              fault,
    input logic [DATA_W-1:0] old_val,
    input logic [5:0]        flags
);
    // R2
    lock_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata))));

    // R10
    release_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_lock && !mem_req));

    // R10
    result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || fault) |-> ($stable(old_val) && $stable(flags)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

endmodule

bind cond_xadd_unit cxa_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_rsp   (mem_rsp),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .fault     (fault),
    .old_val   (old_val),
    .flags     (flags)
);

// File: tb/sim_cond_xadd_unit.sv
module sim_cond_xadd_unit;
    localparam int DW = 64;
    localparam int AW = 16;
    localparam int NV = 20;
    localparam int VW = 198;

    // {op[4], wide[1], mem[64], cmp[64], add[64], take[1]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'h4, 1'b1, 64'd5, 64'd5, 64'd3, 1'b1},
        {4'h5, 1'b1, 64'd5, 64'd5, 64'd3, 1'b0},
        {4'h2, 1'b1, 64'd3, 64'd5, 64'd1, 1'b1},
        {4'h3, 1'b1, 64'd3, 64'd5, 64'd1, 1'b0},
        {4'h2, 1'b0, 64'hABCD_0000_FFFF_FFFF, 64'd1, 64'd1, 1'b0},
        {4'hC, 1'b0, 64'hABCD_0000_FFFF_FFFF, 64'd1, 64'd2, 1'b1},
        {4'hD, 1'b0, 64'hABCD_0000_FFFF_FFFF, 64'd1, 64'd2, 1'b0},
        {4'hE, 1'b1, 64'd7, 64'd7, 64'd1, 1'b1},
        {4'hE, 1'b1, 64'd8, 64'd7, 64'd1, 1'b0},
        {4'h6, 1'b1, 64'd7, 64'd7, 64'd1, 1'b1},
        {4'h7, 1'b1, 64'd8, 64'd7, 64'd1, 1'b1},
        {4'h8, 1'b1, 64'd1, 64'd2, 64'd4, 1'b1},
        {4'h9, 1'b0, 64'h8000_0000, 64'd0, 64'd1, 1'b0},
        {4'hA, 1'b1, 64'd3, 64'd0, 64'd1, 1'b1},
        {4'hA, 1'b1, 64'd1, 64'd0, 64'd1, 1'b0},
        {4'hB, 1'b1, 64'h107, 64'd0, 64'd1, 1'b1},
        {4'h0, 1'b0, 64'h7FFF_FFFF, 64'hFFFF_FFFF, 64'd1, 1'b1},
        {4'h1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0},
        {4'h0, 1'b1, 64'h8000_0000_0000_0000, 64'd1, 64'd5, 1'b1},
        {4'hC, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd1, 64'd2, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op_code = '0;
    logic          wide = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] cmp_val = '0;
    logic [DW-1:0] add_val = '0;
    logic          mem_req, mem_we, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rsp = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_fault = 1'b0;
    logic          done, fault;
    logic [DW-1:0] old_val;
    logic [5:0]    flags;

    logic [DW-1:0] mem_arr [16];
    logic          pl_we = 1'b0;
    logic [3:0]    pl_idx = '0;
    logic [DW-1:0] pl_val = '0;
    logic          fault_rd = 1'b0;
    logic          fault_wr = 1'b0;
    int            rd_cnt = 0;
    int            wr_cnt = 0;
    int            nolock_cnt = 0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic got_done, got_fault;
    logic [DW-1:0] got_old;
    logic [5:0]    got_flags;

    always #5 clk = ~clk;

    cond_xadd_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .wide(wide),
        .addr(addr), .cmp_val(cmp_val), .add_val(add_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp(mem_rsp), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .done(done), .fault(fault), .old_val(old_val), .flags(flags)
    );

    // Memory responder: one response per request, one cycle later
    always @(posedge clk) begin
        if (pl_we) mem_arr[pl_idx] <= pl_val;
        if (mem_req && !mem_rsp) begin
            mem_rsp <= 1'b1;
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                if (!mem_lock) nolock_cnt <= nolock_cnt + 1;
                if (!fault_wr) mem_arr[mem_addr[3:0]] <= mem_wdata;
                mem_fault <= fault_wr;
            end else begin
                rd_cnt    <= rd_cnt + 1;
                mem_rdata <= mem_arr[mem_addr[3:0]];
                mem_fault <= fault_rd;
            end
        end else begin
            mem_rsp   <= 1'b0;
            mem_fault <= 1'b0;
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles > 20000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_flags(input logic [DW-1:0] m, input logic [DW-1:0] c,
                                             input logic w);
        logic [DW-1:0] mask, mm, cc, d, ov;
        logic of, sf, zf, af, pf, cf;
        mask = w ? {DW{1'b1}} : 64'h0000_0000_FFFF_FFFF;
        mm = m & mask;
        cc = c & mask;
        d  = (mm - cc) & mask;
        ov = (mm ^ cc) & (mm ^ d);
        of = w ? ov[63] : ov[31];
        sf = w ? d[63] : d[31];
        zf = (d == '0);
        af = (mm[3:0] < cc[3:0]);
        pf = ~^d[7:0];
        cf = (mm < cc);
        return {of, sf, zf, af, pf, cf};
    endfunction

    task automatic poke(input logic [3:0] idx, input logic [DW-1:0] val);
        @(negedge clk);
        pl_we  = 1'b1;
        pl_idx = idx;
        pl_val = val;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic run_op(input logic [3:0] op, input logic w, input logic [AW-1:0] a,
                          input logic [DW-1:0] c, input logic [DW-1:0] ad, input logic extra);
        int n;
        @(negedge clk);
        op_code = op; wide = w; addr = a; cmp_val = c; add_val = ad;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra) begin
            addr = a + 1; cmp_val = '0; op_code = 4'h4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n = n + 1;
        end
        got_done  = done;
        got_fault = fault;
        got_old   = old_val;
        got_flags = flags;
        chk(got_done, "R11", "done seen", {63'd0, got_done}, 64'd1);
        chk(!mem_lock, "R3", "lock released at done", {63'd0, mem_lock}, 64'd0);
        @(negedge clk);
        chk(!done, "R11", "done one cycle", {63'd0, done}, 64'd0);
    endtask

    initial begin
        logic [DW-1:0] prev_old, expv;
        logic [5:0]    prev_flags;
        int            w0, r0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !fault, "R1", "done/fault after reset", {62'd0, done, fault}, 64'd0);
        chk(!mem_req && !mem_we && !mem_lock, "R1", "memory port idle after reset",
            {61'd0, mem_req, mem_we, mem_lock}, 64'd0);
        chk(old_val == '0 && flags == '0, "R1", "results cleared after reset",
            {52'd0, 6'd0, flags} | old_val, 64'd0);

        // Table walk: R4 R5 R6 R7 R8 R9 R3
        for (int i = 0; i < NV; i++) begin
            logic [3:0]    op;
            logic          w, tk;
            logic [DW-1:0] m, c, ad, mask, newv;
            {op, w, m, c, ad, tk} = VEC[i];
            mask = w ? {DW{1'b1}} : 64'h0000_0000_FFFF_FFFF;
            poke(i[3:0], m);
            w0 = wr_cnt;
            run_op(op, w, AW'(i[3:0]), c, ad, 1'b0);
            chk((wr_cnt - w0) == (tk ? 1 : 0), "R4", $sformatf("vec %0d write issued", i),
                64'(wr_cnt - w0), tk ? 64'd1 : 64'd0);
            chk(!got_fault, "R9", $sformatf("vec %0d no fault", i), {63'd0, got_fault}, 64'd0);
            chk(got_old == (m & mask), "R8", $sformatf("vec %0d old value", i), got_old, m & mask);
            chk(got_flags == exp_flags(m, c, w), "R5", $sformatf("vec %0d flags", i),
                {58'd0, got_flags}, {58'd0, exp_flags(m, c, w)});
            newv = tk ? ((m + ad) & mask) : m;
            chk(mem_arr[i[3:0]] == newv, tk ? "R9" : "R3", $sformatf("vec %0d memory", i),
                mem_arr[i[3:0]], newv);
        end

        // R10: read fault leaves results untouched, no write
        prev_old = got_old; prev_flags = got_flags;
        poke(4'd2, 64'd9);
        fault_rd = 1'b1;
        w0 = wr_cnt;
        run_op(4'h4, 1'b1, 16'd2, 64'd9, 64'd1, 1'b0);
        fault_rd = 1'b0;
        chk(got_fault, "R10", "read fault flagged", {63'd0, got_fault}, 64'd1);
        chk(got_old == prev_old && got_flags == prev_flags, "R10", "results kept on read fault",
            got_old ^ {58'd0, got_flags}, prev_old ^ {58'd0, prev_flags});
        chk(wr_cnt == w0, "R10", "no write after read fault", 64'(wr_cnt - w0), 64'd0);

        // R10: write fault leaves results and memory untouched
        fault_wr = 1'b1;
        w0 = wr_cnt;
        run_op(4'h4, 1'b1, 16'd2, 64'd9, 64'd1, 1'b0);
        fault_wr = 1'b0;
        chk(got_fault, "R10", "write fault flagged", {63'd0, got_fault}, 64'd1);
        chk(got_old == prev_old && got_flags == prev_flags, "R10", "results kept on write fault",
            got_old ^ {58'd0, got_flags}, prev_old ^ {58'd0, prev_flags});
        chk(wr_cnt - w0 == 1, "R10", "write attempted once", 64'(wr_cnt - w0), 64'd1);
        chk(mem_arr[2] == 64'd9, "R10", "memory unchanged on write fault", mem_arr[2], 64'd9);

        // R9: clean retry commits
        run_op(4'h4, 1'b1, 16'd2, 64'd9, 64'd1, 1'b0);
        chk(!got_fault && got_old == 64'd9, "R9", "retry old value", got_old, 64'd9);
        chk(mem_arr[2] == 64'd10, "R9", "retry memory sum", mem_arr[2], 64'd10);

        // R11: start while busy is ignored
        poke(4'd5, 64'd20);
        poke(4'd6, 64'd0);
        r0 = rd_cnt;
        run_op(4'h4, 1'b1, 16'd5, 64'd20, 64'd2, 1'b1);
        chk(rd_cnt - r0 == 1, "R11", "single read despite extra start", 64'(rd_cnt - r0), 64'd1);
        chk(got_old == 64'd20 && mem_arr[5] == 64'd22, "R11", "first operation kept",
            mem_arr[5], 64'd22);
        chk(mem_arr[6] == 64'd0, "R11", "second address untouched", mem_arr[6], 64'd0);
        repeat (3) @(negedge clk);
        chk(!mem_req, "R11", "no request after extra start", {63'd0, mem_req}, 64'd0);

        // R2: every write carried the lock
        chk(nolock_cnt == 0, "R2", "unlocked writes", 64'(nolock_cnt), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule